// File: doc/BRIEF.md
# Precise Exception Tracking Pipeline

This block is the control skeleton of a five-stage in-order pipeline: fetch, decode, execute, memory access and writeback. It models no instruction semantics. Each instruction carries its PC, a valid bit and a four-bit cause vector from stage to stage. Any of the first four stages may report a fault for the instruction it holds in that cycle, and the fault is ORed into that instruction's cause vector. Nothing is acted on when a fault is detected. The vector is judged only when the instruction sits in writeback. Faults are therefore taken in program order, and the oldest faulting instruction always wins, even when a younger one faulted earlier in time.

When the writeback instruction has a non-zero vector, the block raises a trap. All older instructions have already retired. Every younger instruction still in the pipeline becomes a bubble. The faulting PC and its full vector are latched, and the next fetch comes from the handler address. A return input reloads fetch from the saved PC and flushes the handler instructions still in flight. No data stream enters or leaves the block, so there is no valid/ready interface. Every pin is a plain, level-sampled control or status signal.

Top module: `precise_trap_pipe`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` equals `RESET_PC`, `wb_valid`, `rf_we` and `trap` are 0, and `epc` and `cause` are 0.
- R2: When there is no trap and no return, `fetch_pc` advances by `STEP` (default 4) each cycle. An instruction fetched in cycle c is in writeback, with `wb_valid` high and `wb_pc` equal to its PC, in cycle c+4.
- R3: A valid writeback instruction with an all-zero cause vector drives `rf_we` high and `trap` low in that cycle.
- R4: A fault input raised while a valid instruction occupies that stage sets a fixed bit of that instruction's vector. The bits are 0 for `fault_if`, 1 for `fault_id`, 2 for `fault_ex` and 3 for `fault_mem`. Several faults on one instruction accumulate.
- R5: `trap` is high only in a cycle where a valid writeback instruction has a non-zero vector. In that cycle `rf_we` is 0.
- R6: An instruction that faults in memory access traps before a younger instruction that faulted earlier in time in fetch. The younger fault is never taken.
- R7: On a trap or a return, every instruction in fetch through memory access is quashed and never appears with `wb_valid` high.
- R8: The cycle after a trap, `epc` holds the faulting PC and `cause` holds its whole vector.
- R9: The cycle after a trap, `fetch_pc` equals `TRAP_VEC`.
- R10: When `rfe` is high without a trap, the next cycle's `fetch_pc` equals `epc`, and the in-flight instructions are quashed. Trap takes priority over return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_if | input | 1 | Fault on the instruction now in fetch |
| fault_id | input | 1 | Illegal instruction fault on the instruction now in decode |
| fault_ex | input | 1 | Fault on the instruction now in execute |
| fault_mem | input | 1 | Fault on the instruction now in memory access |
| rfe | input | 1 | Return from exception: resume fetch at `epc` |
| fetch_pc | output | PC_W | PC of the instruction fetched this cycle |
| wb_valid | output | 1 | A real instruction (not a bubble) is in writeback |
| wb_pc | output | PC_W | PC of the writeback instruction |
| rf_we | output | 1 | Register-file write enable for a clean writeback instruction |
| trap | output | 1 | The writeback instruction is faulting |
| epc | output | PC_W | Saved PC of the last trapping instruction |
| cause | output | 4 | Saved cause vector of the last trapping instruction |

## Verification
Each result is due at a fixed cycle:
- Writeback status, `rf_we` and `trap` appear four cycles after fetch.
- `epc`, `cause` and the handler fetch appear one cycle after `trap`.
- The resumed `fetch_pc` appears one cycle after `rfe`.
- The resumed instruction reaches writeback four cycles after that.

The bench keeps a history of fetched PCs to drive each stage's fault input while the targeted instruction occupies that stage. It queues the expected writeback sequence per scenario and compares it against every valid writeback, sampling on the falling edge. The one-cycle-later values are checked on the falling edge after the trap or return.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int NCAUSE = 4;
  typedef logic [NCAUSE-1:0] cause_t;
  typedef enum int {
    CB_FETCH = 0,
    CB_ILLEGAL = 1,
    CB_EXEC = 2,
    CB_MEM = 3
  } cause_bit_e;
endpackage

// File: rtl/pt_fetch.sv
module pt_fetch #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter logic [PC_W-1:0] TRAP_VEC = '0,
  parameter logic [PC_W-1:0] STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic            rfe_i,
  input  logic [PC_W-1:0] epc_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_o <= RESET_PC;
    else if (trap_i) pc_o <= TRAP_VEC;
    else if (rfe_i)  pc_o <= epc_i;
    else             pc_o <= pc_o + STEP;
  end

  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_i && !rfe_i) |=> (pc_o == $past(pc_o) + STEP));
  p_handler_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (pc_o == TRAP_VEC));
  p_resume_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !trap_i) |=> (pc_o == $past(epc_i)));
endmodule

// File: rtl/pt_stage.sv
module pt_stage
  import pt_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int CBIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_t          vec_i,
  input  logic            fault_i,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o,
  output cause_t          vec_o
);
  cause_t post;
  always_comb begin
    post = '0;
    post[CBIT] = fault_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      vec_o   <= '0;
    end else begin
      valid_o <= valid_i && !flush_i;
      pc_o    <= pc_i;
      vec_o   <= vec_i | post;
    end
  end

  p_quash_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !valid_o);
  p_post_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fault_i && !flush_i) |=> (valid_o && vec_o[CBIT]));
endmodule

// File: rtl/pt_trap_unit.sv
module pt_trap_unit
  import pt_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_valid_i,
  input  logic [PC_W-1:0] wb_pc_i,
  input  cause_t          wb_vec_i,
  output logic            trap_o,
  output logic            rf_we_o,
  output logic [PC_W-1:0] epc_o,
  output cause_t          cause_o
);
  logic faulty;
  assign faulty  = |wb_vec_i;
  assign trap_o  = wb_valid_i && faulty;
  assign rf_we_o = wb_valid_i && !faulty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o   <= '0;
      cause_o <= '0;
    end else if (trap_o) begin
      epc_o   <= wb_pc_i;
      cause_o <= wb_vec_i;
    end
  end

  p_save_epc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (epc_o == $past(wb_pc_i)));
  p_save_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (cause_o == $past(wb_vec_i)));
endmodule

// File: rtl/precise_trap_pipe.sv
module precise_trap_pipe
  import pt_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0100,
  parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080,
  parameter logic [PC_W-1:0] STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_if,
  input  logic            fault_id,
  input  logic            fault_ex,
  input  logic            fault_mem,
  input  logic            rfe,
  output logic [PC_W-1:0] fetch_pc,
  output logic            wb_valid,
  output logic [PC_W-1:0] wb_pc,
  output logic            rf_we,
  output logic            trap,
  output logic [PC_W-1:0] epc,
  output logic [3:0]      cause
);
  localparam int NST = NCAUSE;

  logic            sv [NST+1];
  logic [PC_W-1:0] sp [NST+1];
  cause_t          sc [NST+1];
  cause_t          faults;
  logic            flush;
  logic            trap_w;
  logic [PC_W-1:0] epc_w;

  assign faults[CB_FETCH]   = fault_if;
  assign faults[CB_ILLEGAL] = fault_id;
  assign faults[CB_EXEC]    = fault_ex;
  assign faults[CB_MEM]     = fault_mem;

  assign flush = trap_w || rfe;

  pt_fetch #(.PC_W(PC_W), .RESET_PC(RESET_PC), .TRAP_VEC(TRAP_VEC), .STEP(STEP)) u_fetch (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_w), .rfe_i(rfe), .epc_i(epc_w), .pc_o(fetch_pc)
  );

  assign sv[0] = 1'b1;
  assign sp[0] = fetch_pc;
  assign sc[0] = '0;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    pt_stage #(.PC_W(PC_W), .CBIT(k)) u_stage (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .valid_i(sv[k]), .pc_i(sp[k]), .vec_i(sc[k]), .fault_i(faults[k]),
      .valid_o(sv[k+1]), .pc_o(sp[k+1]), .vec_o(sc[k+1])
    );
  end

  pt_trap_unit #(.PC_W(PC_W)) u_trap (
    .clk(clk), .rst_n(rst_n),
    .wb_valid_i(sv[NST]), .wb_pc_i(sp[NST]), .wb_vec_i(sc[NST]),
    .trap_o(trap_w), .rf_we_o(rf_we), .epc_o(epc_w), .cause_o(cause)
  );

  assign trap     = trap_w;
  assign epc      = epc_w;
  assign wb_valid = sv[NST];
  assign wb_pc    = sp[NST];

  p_trap_needs_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (wb_valid && !rf_we));
endmodule

// File: tb/precise_trap_pipe_test.sv
module precise_trap_pipe_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] RST = 32'h100;
  localparam logic [31:0] TV  = 32'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_if = 0, fault_id = 0, fault_ex = 0, fault_mem = 0, rfe = 0;
  logic [31:0] fetch_pc, wb_pc, epc;
  logic wb_valid, rf_we, trap;
  logic [3:0] cause;

  precise_trap_pipe uut (
    .clk(clk), .rst_n(rst_n), .fault_if(fault_if), .fault_id(fault_id),
    .fault_ex(fault_ex), .fault_mem(fault_mem), .rfe(rfe), .fetch_pc(fetch_pc),
    .wb_valid(wb_valid), .wb_pc(wb_pc), .rf_we(rf_we), .trap(trap),
    .epc(epc), .cause(cause)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [31:0] pc;
    logic [3:0]  cz;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  logic [3:0] fmask [logic [31:0]];
  logic [31:0] hist [5];
  int checks = 0, fails = 0;
  bit pend = 0;
  logic [31:0] tpc;
  logic [3:0] tcz;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [3:0] fm(input logic [31:0] pc);
    return fmask.exists(pc) ? fmask[pc] : 4'b0;
  endfunction

  task automatic push(input logic [31:0] pc, input logic [3:0] cz, input string req);
    exp_t e;
    e.pc = pc; e.cz = cz; e.req = req;
    exp_q.push_back(e);
  endtask

  // fault driver: stage k holds the instruction fetched k cycles ago
  always @(negedge clk) begin
    for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = fetch_pc;
    fault_if  = fm(hist[0])[0];
    fault_id  = fm(hist[1])[1];
    fault_ex  = fm(hist[2])[2];
    fault_mem = fm(hist[3])[3];
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk(epc == tpc, "R8", "epc", epc, tpc);
        chk(cause == tcz, "R8", "cause", {28'b0, cause}, {28'b0, tcz});
        chk(fetch_pc == TV, "R9", "fetch_pc", fetch_pc, TV);
        pend = 0;
      end
      if (wb_valid && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(wb_pc == e.pc, e.req, "wb_pc", wb_pc, e.pc);
        if (e.cz == 4'b0) begin
          chk(rf_we == 1'b1, "R3", "rf_we", {31'b0, rf_we}, 32'd1);
          chk(trap == 1'b0, "R5", "trap", {31'b0, trap}, 32'd0);
        end else begin
          chk(trap == 1'b1, "R5", "trap", {31'b0, trap}, 32'd1);
          chk(rf_we == 1'b0, "R5", "rf_we", {31'b0, rf_we}, 32'd0);
          pend = 1; tpc = e.pc; tcz = e.cz;
        end
      end
    end
  end

  task automatic do_reset;
    rst_n = 1'b0; rfe = 1'b0;
    fmask.delete(); exp_q.delete(); pend = 0;
    repeat (3) @(negedge clk);
    chk(fetch_pc == RST, "R1", "fetch_pc", fetch_pc, RST);
    chk(!wb_valid && !rf_we && !trap, "R1", "wb_valid/rf_we/trap",
        {29'b0, wb_valid, rf_we, trap}, 32'd0);
    chk(epc == 0 && cause == 0, "R1", "epc/cause", epc | {28'b0, cause}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic drain;
    int n = 0;
    do begin
      @(negedge clk); #1; n++;
    end while (exp_q.size() != 0 && n < 200);
    if (exp_q.size() != 0) chk(0, "R2", "writeback stream stalled", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // clean sequential flow
    do_reset();
    for (int i = 0; i < 10; i++) push(RST + 32'(4*i), 4'b0, "R2");
    drain();

    // fetch fault, younger quashed
    do_reset();
    fmask[32'h10C] = 4'b0001;
    push(32'h100, 0, "R3"); push(32'h104, 0, "R3"); push(32'h108, 0, "R3");
    push(32'h10C, 4'b0001, "R4");
    push(TV, 0, "R7"); push(TV + 4, 0, "R9");
    drain();

    // older MEM fault beats younger earlier IF fault
    do_reset();
    fmask[32'h114] = 4'b1000;
    fmask[32'h118] = 4'b0001;
    for (int i = 0; i < 5; i++) push(RST + 32'(4*i), 0, "R2");
    push(32'h114, 4'b1000, "R6");
    push(TV, 0, "R7"); push(TV + 4, 0, "R7");
    drain();

    // accumulated causes, younger EX fault quashed
    do_reset();
    fmask[32'h108] = 4'b0110;
    fmask[32'h110] = 4'b0100;
    push(32'h100, 0, "R2"); push(32'h104, 0, "R2");
    push(32'h108, 4'b0110, "R4");
    push(TV, 0, "R7"); push(TV + 4, 0, "R7");
    drain();

    // illegal fault then return from exception
    do_reset();
    fmask[32'h104] = 4'b0010;
    push(32'h100, 0, "R3");
    push(32'h104, 4'b0010, "R5");
    push(TV, 0, "R9"); push(TV + 4, 0, "R9");
    drain();
    rfe = 1'b1;
    fmask.delete();
    push(32'h104, 0, "R10"); push(32'h108, 0, "R10"); push(32'h10C, 0, "R10");
    @(negedge clk);
    chk(fetch_pc == 32'h104, "R10", "fetch_pc after rfe", fetch_pc, 32'h104);
    chk(!wb_valid, "R10", "wb_valid after rfe", {31'b0, wb_valid}, 32'd0);
    rfe = 1'b0;
    drain();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule